// File: doc/BRIEF.md
# Masked Vector Lane ALU

This unit executes one element-wise integer vector operation per accepted request. The register width `VLEN` is a parameter, and the request selects the active element width and the active element count. The second operand comes from one of three places: a second vector, a scalar that is shared by every element, or a sign-extended 5-bit immediate. A mask vector holds one bit per element. When masking is requested, that mask decides which elements are written. Elements that are not written pass through from the caller's old destination value.

Besides wrap-around arithmetic and bitwise logic, the unit produces compare masks, combines two masks bit by bit, and folds the active elements of a vector into a scalar. The fold is seeded by element 0 of the second vector and is written to element 0 of the destination. The caller supplies the old destination vector with every request. The result appears one clock later together with a valid strobe.

The control is a two-state machine. State `ST_IDLE` means no result is presented. State `ST_OUT` means `vd` holds the result of the request accepted on the previous edge.
- Transition *accept*: from either state to `ST_OUT` when `start` is high.
- Transition *retire*: from either state to `ST_IDLE` when `start` is low.

Top module: `vec_lane_alu`

## Requirements
- R1: After reset `out_valid` is 0 and `vd` is all zero. A request sampled with `start`=1 sets `out_valid`=1 and its result on `vd` in the next cycle. A cycle without `start` leaves `out_valid`=0 in the following cycle.
- R2: `sew` selects the element width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. Element i occupies bits [i*SEW +: SEW]. A `vl` above VLEN/SEW acts as VLEN/SEW.
- R3: Element op codes are ADD=0, SUB=1, AND=2, OR=3, XOR=4. The result is vs2[i] op operand, taken modulo 2^SEW. SUB computes vs2 minus the operand.
- R4: `mode` selects the operand. 0 uses vs1[i]. 1 uses the low SEW bits of `scalar` for every element. 2 or 3 uses `imm` sign-extended to SEW.
- R5: With `masked`=1, an element, compare bit or fold input is used only where `vmask[i]`=1. Any other element or compare bit takes its value from `vd_old`.
- R6: Elements, and compare or mask bits, at index `vl` and above always equal `vd_old`. With `vl`=0, `vd` equals `vd_old` for every operation.
- R7: Compare op codes are EQ=5, LT=6, LE=7, GT=8, using signed SEW-bit values. The compare writes bit i of `vd` as 1 when vs2[i] relates to the operand as named, and 0 otherwise.
- R8: Mask op codes are AND=9, OR=10, XOR=11, NAND=12. Each applies bitwise to bits i < effective vl of vs2 and vs1. `masked` has no effect on these ops.
- R9: Fold op codes are SUM=13, MAX=14, MIN=15, AND=16, OR=17, XOR=18. The fold starts from element 0 of vs1 and combines it with the active elements of vs2. MAX and MIN are signed. The result goes to element 0 of `vd`; every other bit of `vd` equals `vd_old`.
- R10: A masked fold uses only the elements whose mask bit is 1. When no element is enabled, element 0 receives the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a request this cycle |
| op | input | 5 | Operation code |
| mode | input | 2 | Operand source select |
| sew | input | 2 | Element width select |
| vl | input | VLW | Active element count |
| masked | input | 1 | Enable per-element masking |
| vs2 | input | VLEN | First source vector |
| vs1 | input | VLEN | Second source vector, also the fold seed |
| scalar | input | XLEN | Shared scalar operand |
| imm | input | 5 | Signed immediate operand |
| vmask | input | VLEN | Mask, one bit per element |
| vd_old | input | VLEN | Prior destination value |
| out_valid | output | 1 | Result valid |
| vd | output | VLEN | Result vector |

## Verification
The assertions check four properties on every cycle: the valid timing, that `vl`=0 leaves the destination unchanged, that an all-zero mask on element and compare ops preserves the destination, and that a fold never touches bits above element 0. The bench scenarios are needed for the rest: the arithmetic values, wrap-around, signed compare edges, and the operand source. They also cover clamping of `vl`, partial masks, the mask-logic truth tables and fold seeding, because these depend on the data and on the element layout.

// File: rtl/vlalu_pkg.sv
package vlalu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_AND   = 5'd2,
        OP_OR    = 5'd3,
        OP_XOR   = 5'd4,
        OP_CEQ   = 5'd5,
        OP_CLT   = 5'd6,
        OP_CLE   = 5'd7,
        OP_CGT   = 5'd8,
        OP_MAND  = 5'd9,
        OP_MOR   = 5'd10,
        OP_MXOR  = 5'd11,
        OP_MNAND = 5'd12,
        OP_RSUM  = 5'd13,
        OP_RMAX  = 5'd14,
        OP_RMIN  = 5'd15,
        OP_RAND  = 5'd16,
        OP_ROR   = 5'd17,
        OP_RXOR  = 5'd18
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_VEC = 2'd0,
        SRC_SCL = 2'd1,
        SRC_IMM = 2'd2
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } fsm_e;

    function automatic logic is_fold(input logic [4:0] o);
        return (o >= OP_RSUM) && (o <= OP_RXOR);
    endfunction

    function automatic logic is_mlog(input logic [4:0] o);
        return (o >= OP_MAND) && (o <= OP_MNAND);
    endfunction

endpackage

// File: rtl/vlalu_elem.sv
module vlalu_elem
    import vlalu_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int W    = 8,
    parameter int XLEN = 32,
    parameter int VLW  = 5
) (
    input  logic [4:0]      op,
    input  logic [1:0]      mode,
    input  logic [VLW-1:0]  vl,
    input  logic            masked,
    input  logic [VLEN-1:0] vs2,
    input  logic [VLEN-1:0] vs1,
    input  logic [XLEN-1:0] scalar,
    input  logic [4:0]      imm,
    input  logic [VLEN-1:0] vmask,
    input  logic [VLEN-1:0] vd_old,
    output logic [VLEN-1:0] res
);
    localparam int NE = VLEN / W;

    always_comb begin
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         act;
        res = vd_old;
        for (int i = 0; i < NE; i++) begin
            a = vs2[i*W +: W];
            case (mode)
                SRC_VEC: b = vs1[i*W +: W];
                SRC_SCL: b = scalar[W-1:0];
                default: b = {{(W-5){imm[4]}}, imm};
            endcase
            act = (i < int'(vl)) && (!masked || vmask[i]);
            if (act) begin
                case (alu_op_e'(op))
                    OP_ADD: res[i*W +: W] = a + b;
                    OP_SUB: res[i*W +: W] = a - b;
                    OP_AND: res[i*W +: W] = a & b;
                    OP_OR:  res[i*W +: W] = a | b;
                    OP_XOR: res[i*W +: W] = a ^ b;
                    OP_CEQ: res[i] = (a == b);
                    OP_CLT: res[i] = ($signed(a) <  $signed(b));
                    OP_CLE: res[i] = ($signed(a) <= $signed(b));
                    OP_CGT: res[i] = ($signed(a) >  $signed(b));
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/vlalu_fold.sv
module vlalu_fold
    import vlalu_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int W    = 8,
    parameter int VLW  = 5
) (
    input  logic [4:0]      op,
    input  logic [VLW-1:0]  vl,
    input  logic            masked,
    input  logic [VLEN-1:0] vs2,
    input  logic [VLEN-1:0] vs1,
    input  logic [VLEN-1:0] vmask,
    input  logic [VLEN-1:0] vd_old,
    output logic [VLEN-1:0] res
);
    localparam int NE = VLEN / W;

    always_comb begin
        logic [W-1:0] acc;
        logic [W-1:0] e;
        acc = vs1[W-1:0];
        for (int i = 0; i < NE; i++) begin
            e = vs2[i*W +: W];
            if ((i < int'(vl)) && (!masked || vmask[i])) begin
                case (alu_op_e'(op))
                    OP_RSUM: acc = acc + e;
                    OP_RMAX: if ($signed(e) > $signed(acc)) acc = e;
                    OP_RMIN: if ($signed(e) < $signed(acc)) acc = e;
                    OP_RAND: acc = acc & e;
                    OP_ROR:  acc = acc | e;
                    OP_RXOR: acc = acc ^ e;
                    default: ;
                endcase
            end
        end
        res = vd_old;
        if (vl != '0) res[W-1:0] = acc;
    end

endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
    import vlalu_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int XLEN = 32,
    parameter int VLW  = $clog2(VLEN/8 + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [4:0]      op,
    input  logic [1:0]      mode,
    input  logic [1:0]      sew,
    input  logic [VLW-1:0]  vl,
    input  logic            masked,
    input  logic [VLEN-1:0] vs2,
    input  logic [VLEN-1:0] vs1,
    input  logic [XLEN-1:0] scalar,
    input  logic [4:0]      imm,
    input  logic [VLEN-1:0] vmask,
    input  logic [VLEN-1:0] vd_old,
    output logic            out_valid,
    output logic [VLEN-1:0] vd
);
    localparam int NWID = 3;
    localparam int MAXE = VLEN / 8;

    logic [VLEN-1:0] ew_res [NWID];
    logic [VLEN-1:0] fd_res [NWID];
    logic [VLEN-1:0] ml_res;
    logic [VLEN-1:0] nxt_vd;
    logic [VLEN-1:0] vd_q;
    logic [1:0]      wsel;
    fsm_e            state, nstate;

    for (genvar g = 0; g < NWID; g++) begin : g_width
        localparam int WG = 8 << g;
        vlalu_elem #(.VLEN(VLEN), .W(WG), .XLEN(XLEN), .VLW(VLW)) u_elem (
            .op(op), .mode(mode), .vl(vl), .masked(masked),
            .vs2(vs2), .vs1(vs1), .scalar(scalar), .imm(imm),
            .vmask(vmask), .vd_old(vd_old), .res(ew_res[g])
        );
        vlalu_fold #(.VLEN(VLEN), .W(WG), .VLW(VLW)) u_fold (
            .op(op), .vl(vl), .masked(masked), .vs2(vs2), .vs1(vs1),
            .vmask(vmask), .vd_old(vd_old), .res(fd_res[g])
        );
    end

    assign wsel = (sew >= 2'd2) ? 2'd2 : sew;

    // mask-register logic: bitwise over the effective element count
    always_comb begin
        int cap;
        int evl;
        cap = MAXE >> wsel;
        evl = (int'(vl) < cap) ? int'(vl) : cap;
        ml_res = vd_old;
        for (int i = 0; i < MAXE; i++) begin
            if (i < evl) begin
                case (alu_op_e'(op))
                    OP_MAND:  ml_res[i] = vs2[i] & vs1[i];
                    OP_MOR:   ml_res[i] = vs2[i] | vs1[i];
                    OP_MXOR:  ml_res[i] = vs2[i] ^ vs1[i];
                    OP_MNAND: ml_res[i] = ~(vs2[i] & vs1[i]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        if (is_fold(op))      nxt_vd = fd_res[wsel];
        else if (is_mlog(op)) nxt_vd = ml_res;
        else                  nxt_vd = ew_res[wsel];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions: accept (start) and retire (no start)
    always_comb begin
        unique case (state)
            ST_IDLE: nstate = start ? ST_OUT : ST_IDLE;
            ST_OUT:  nstate = start ? ST_OUT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     vd_q <= '0;
        else if (start) vd_q <= nxt_vd;
    end

    // outputs
    always_comb begin
        out_valid = (state == ST_OUT);
        vd        = vd_q;
    end

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> out_valid); // R1
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !out_valid); // R1
    AST_ZERO_VL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (start && vl == '0) |=> (vd == $past(vd_old))); // R6
    AST_MASK_OFF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (start && masked && vmask == '0 && !is_fold(op) && !is_mlog(op)) |=> (vd == $past(vd_old))); // R5
    AST_FOLD_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && is_fold(op)) |=> (vd[VLEN-1:XLEN] == $past(vd_old[VLEN-1:XLEN]))); // R9

endmodule

// File: tb/sim_vec_lane_alu.sv
module sim_vec_lane_alu;
    import vlalu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int VLEN = 128;
    localparam int XLEN = 32;
    localparam int VLW  = $clog2(VLEN/8 + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [4:0]      op = '0;
    logic [1:0]      mode = '0;
    logic [1:0]      sew = '0;
    logic [VLW-1:0]  vl = '0;
    logic            masked = 1'b0;
    logic [VLEN-1:0] vs2 = '0, vs1 = '0, vmask = '0, vd_old = '0;
    logic [XLEN-1:0] scalar = '0;
    logic [4:0]      imm = '0;
    logic            out_valid;
    logic [VLEN-1:0] vd;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_lane_alu #(.VLEN(VLEN), .XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode),
        .sew(sew), .vl(vl), .masked(masked), .vs2(vs2), .vs1(vs1),
        .scalar(scalar), .imm(imm), .vmask(vmask), .vd_old(vd_old),
        .out_valid(out_valid), .vd(vd)
    );

    task automatic chk(input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [4:0] o, input logic [1:0] m, input logic [1:0] s,
                       input logic [VLW-1:0] l, input logic mk,
                       input logic [VLEN-1:0] a2, input logic [VLEN-1:0] a1,
                       input logic [XLEN-1:0] sc, input logic [4:0] im,
                       input logic [VLEN-1:0] msk, input logic [VLEN-1:0] old);
        @(negedge clk);
        op = o; mode = m; sew = s; vl = l; masked = mk; vs2 = a2; vs1 = a1;
        scalar = sc; imm = im; vmask = msk; vd_old = old; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset valid", {127'b0, out_valid}, '0);
        chk("R1 reset vd", vd, '0);
    endtask

    task automatic t_add_vv;
        run(OP_ADD, 2'd0, 2'd2, 5'd4, 1'b0,
            {32'd4, 32'd3, 32'd2, 32'hFFFF_FFFF}, {32'd10, 32'd20, 32'd30, 32'd1},
            '0, '0, '0, '0);
        chk("R1 valid after start", {127'b0, out_valid}, 128'd1);
        chk("R3 add wrap", vd, {32'd14, 32'd23, 32'd32, 32'd0});
        @(negedge clk);
        chk("R1 valid drops", {127'b0, out_valid}, '0);
    endtask

    task automatic t_sub_scalar_tail;
        run(OP_SUB, 2'd1, 2'd0, 5'd5, 1'b0, {16{8'h10}}, '0,
            32'h0000_0103, '0, '0, {16{8'hAA}});
        chk("R4 R6 scalar sub with tail", vd, {{11{8'hAA}}, {5{8'h0D}}});
    endtask

    task automatic t_imm;
        run(OP_ADD, 2'd2, 2'd1, 5'd8, 1'b0, {8{16'h0001}}, '0,
            '0, 5'b11110, '0, '0);
        chk("R4 imm sign extend", vd, {8{16'hFFFF}});
    endtask

    task automatic t_masked_xor;
        run(OP_XOR, 2'd0, 2'd2, 5'd4, 1'b1, {4{32'hF0F0_F0F0}}, {4{32'h0F0F_0F0F}},
            '0, '0, 128'b0101, {4{32'h1234_5678}});
        chk("R5 masked xor", vd, {32'h1234_5678, 32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF});
    endtask

    task automatic t_clamp;
        run(OP_AND, 2'd0, 2'd3, 5'd16, 1'b0, {128{1'b1}}, {32'h1, 32'h2, 32'h3, 32'h4},
            '0, '0, '0, '0);
        chk("R2 vl clamp and sew3", vd, {32'h1, 32'h2, 32'h3, 32'h4});
    endtask

    task automatic t_compare;
        logic [VLEN-1:0] src;
        src = {96'h0, 8'h05, 8'h7F, 8'h05, 8'h80};
        run(OP_CLT, 2'd1, 2'd0, 5'd4, 1'b0, src, '0, 32'd5, '0, '0, {128{1'b1}});
        chk("R7 lt signed", vd, {{124{1'b1}}, 4'b0001});
        run(OP_CEQ, 2'd1, 2'd0, 5'd4, 1'b0, src, '0, 32'd5, '0, '0, {128{1'b1}});
        chk("R7 eq", vd, {{124{1'b1}}, 4'b1010});
        run(OP_CLE, 2'd1, 2'd0, 5'd4, 1'b0, src, '0, 32'd5, '0, '0, {128{1'b1}});
        chk("R7 le", vd, {{124{1'b1}}, 4'b1011});
        run(OP_CGT, 2'd1, 2'd0, 5'd4, 1'b0, src, '0, 32'd5, '0, '0, {128{1'b1}});
        chk("R7 gt", vd, {{124{1'b1}}, 4'b0100});
        run(OP_CEQ, 2'd1, 2'd0, 5'd4, 1'b1, src, '0, 32'd5, '0, 128'b0011, {128{1'b1}});
        chk("R5 R7 masked compare", vd, {{124{1'b1}}, 4'b1110});
    endtask

    task automatic t_mask_logic;
        logic [VLEN-1:0] a;
        logic [VLEN-1:0] b;
        a = {{120{1'b0}}, 8'b1100_1100};
        b = {{120{1'b0}}, 8'b1010_1010};
        run(OP_MAND, 2'd0, 2'd0, 5'd8, 1'b0, a, b, '0, '0, '0, {128{1'b1}});
        chk("R8 mask and", vd, {{120{1'b1}}, 8'h88});
        run(OP_MOR, 2'd0, 2'd0, 5'd8, 1'b0, a, b, '0, '0, '0, {128{1'b1}});
        chk("R8 mask or", vd, {{120{1'b1}}, 8'hEE});
        run(OP_MXOR, 2'd0, 2'd0, 5'd8, 1'b0, a, b, '0, '0, '0, {128{1'b1}});
        chk("R8 mask xor", vd, {{120{1'b1}}, 8'h66});
        run(OP_MNAND, 2'd0, 2'd0, 5'd8, 1'b0, a, b, '0, '0, '0, {128{1'b1}});
        chk("R8 mask nand", vd, {{120{1'b1}}, 8'h77});
        run(OP_MNAND, 2'd0, 2'd0, 5'd8, 1'b1, a, b, '0, '0, '0, {128{1'b1}});
        chk("R8 masked flag ignored", vd, {{120{1'b1}}, 8'h77});
    endtask

    task automatic t_fold;
        logic [VLEN-1:0] src;
        logic [VLEN-1:0] seed;
        logic [VLEN-1:0] old;
        src  = {{4{16'h7FFF}}, 16'h8000, 16'h0010, 16'hFFFE, 16'h0003};
        seed = {112'h0, 16'h0005};
        old  = {8{16'hAAAA}};
        run(OP_RSUM, 2'd0, 2'd1, 5'd4, 1'b0, src, seed, '0, '0, '0, old);
        chk("R9 fold sum", vd, {{7{16'hAAAA}}, 16'h8016});
        run(OP_RMAX, 2'd0, 2'd1, 5'd4, 1'b0, src, seed, '0, '0, '0, old);
        chk("R9 fold max", vd, {{7{16'hAAAA}}, 16'h0010});
        run(OP_RMIN, 2'd0, 2'd1, 5'd4, 1'b0, src, seed, '0, '0, '0, old);
        chk("R9 fold min", vd, {{7{16'hAAAA}}, 16'h8000});
        run(OP_RAND, 2'd0, 2'd1, 5'd4, 1'b0, src, seed, '0, '0, '0, old);
        chk("R9 fold and", vd, {{7{16'hAAAA}}, 16'h0000});
        run(OP_ROR, 2'd0, 2'd1, 5'd4, 1'b0, src, seed, '0, '0, '0, old);
        chk("R9 fold or", vd, {{7{16'hAAAA}}, 16'hFFFF});
        run(OP_RXOR, 2'd0, 2'd1, 5'd4, 1'b0, src, seed, '0, '0, '0, old);
        chk("R9 fold xor", vd, {{7{16'hAAAA}}, 16'h7FE8});
        run(OP_RSUM, 2'd0, 2'd1, 5'd4, 1'b1, src, seed, '0, '0, 128'b0101, old);
        chk("R10 masked fold sum", vd, {{7{16'hAAAA}}, 16'h0018});
        run(OP_RMAX, 2'd0, 2'd1, 5'd4, 1'b1, src, seed, '0, '0, '0, old);
        chk("R10 all masked seed", vd, {{7{16'hAAAA}}, 16'h0005});
        run(OP_RSUM, 2'd0, 2'd1, 5'd0, 1'b0, src, seed, '0, '0, '0, old);
        chk("R6 R10 zero vl fold", vd, old);
    endtask

    task automatic t_zero_vl;
        run(OP_ADD, 2'd0, 2'd0, 5'd0, 1'b0, {128{1'b1}}, {128{1'b1}},
            '0, '0, '0, 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677);
        chk("R6 zero vl add", vd, 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add_vv();
        t_sub_scalar_tail();
        t_imm();
        t_masked_xor();
        t_clamp();
        t_compare();
        t_mask_logic();
        t_fold();
        t_zero_vl();
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule